// File: doc/BRIEF.md
# Delayed Request Retry Scheduler

This block decides which of a small set of queued delayed requests is tried next on the target bus. Each slot holds one pending request. The owner of the slots sets each slot's valid bit and clears it. The scheduler raises a launch strobe together with a slot index. It then waits until the attempt ends. The end of an attempt is reported as a done pulse with a two-bit outcome.

An input selects one of two policies:

- **Fair mode (0).** The scheduler rotates through the pending slots. A slot that receives a target retry goes to the back of the rotation.
- **Sticky mode (1).** The scheduler locks onto a slot that received a target retry. It keeps relaunching that slot until the slot gets some other answer or is withdrawn.

Only one attempt is outstanding at a time. Signalling on the bus itself is handled elsewhere.

Top module: `retry_sched`

## Requirements
- R1: `launch` is high only in a cycle where at least one slot is valid and no attempt is outstanding, and `launch_slot` then names a valid slot; with no valid slot `launch` stays low, including during reset.
- R2: After a launch no further launch occurs until `attempt_done` has been seen; `attempt_done` while nothing is outstanding is ignored.
- R3: The outcome code is 2'b00 for completion, 2'b01 for target retry, 2'b10 for error; 2'b11 is handled like error.
- R4: In fair mode the search starts at the slot after the one last launched, wrapping from the top slot to slot 0 and skipping slots that are not valid; after reset the search starts at slot 0.
- R5: In fair mode a target retry does not hold the slot: when other slots are valid, the next launch goes to the next valid slot in rotation.
- R6: In sticky mode, after a target retry on a still-valid slot, the next launch is that same slot, and no other slot is launched until it receives a non-retry outcome or is withdrawn.
- R7: In sticky mode a completion or error releases the lock, and selection continues in rotation from the slot after the one released.
- R8: In sticky mode, clearing the valid bit of the locked slot releases the lock at once.
- R9: When a valid slot is waiting, `launch` rises in the cycle right after the cycle carrying `attempt_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | N_SLOTS | One bit per pending request slot |
| sticky_mode | input | 1 | 0: fair rotation, 1: lock onto a retried slot |
| attempt_done | input | 1 | Single-cycle pulse at the end of the outstanding attempt |
| attempt_outcome | input | 2 | Outcome code, qualified by attempt_done |
| launch | output | 1 | Start an attempt on launch_slot this cycle |
| launch_slot | output | $clog2(N_SLOTS) | Index of the slot to attempt |

## Verification
Three pieces of internal state matter here. If the outstanding flag is wrong, the ports show either a second launch before a done or a missing launch in the cycle after a done. If the rotation pointer is wrong, the index of the very next launch is wrong. If the lock state is wrong, a sticky-mode relaunch goes to the wrong slot, or a fair-mode retry returns to the same slot. Each of these faults is visible within one cycle of the `attempt_done` that exposes it. The scoreboard compares every launched index, in order, against the rotation and lock rules.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    OUT_COMPLETE = 2'b00,
    OUT_RETRY    = 2'b01,
    OUT_ERROR    = 2'b10,
    OUT_RSVD     = 2'b11
  } outcome_e;
endpackage

// File: rtl/dts_flight.sv
module dts_flight #(
  parameter int N_SLOTS = 4,
  localparam int IDXW = $clog2(N_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW-1:0] start_slot,
  input  logic            done,
  output logic            busy,
  output logic [IDXW-1:0] busy_slot
);
  logic            busy_d;
  logic [IDXW-1:0] slot_d;
  logic            slot_en;

  always_comb begin
    busy_d  = busy;
    slot_en = 1'b0;
    slot_d  = start_slot;
    if (start) begin
      busy_d  = 1'b1;
      slot_en = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      busy_slot <= '0;
    end else begin
      busy <= busy_d;
      if (slot_en) busy_slot <= slot_d;
    end
  end
endmodule

// File: rtl/dts_rr_pick.sv
module dts_rr_pick #(
  parameter int N_SLOTS = 4,
  localparam int IDXW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] req,
  input  logic               adv,
  input  logic [IDXW-1:0]    adv_slot,
  output logic               found,
  output logic [IDXW-1:0]    pick
);
  logic [IDXW-1:0] ptr;
  logic [IDXW-1:0] ptr_d;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      int idx;
      idx = (int'(ptr) + i) % N_SLOTS;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IDXW'(idx);
      end
    end
  end

  always_comb begin
    if (int'(adv_slot) == N_SLOTS - 1) ptr_d = '0;
    else                               ptr_d = adv_slot + IDXW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end
endmodule

// File: rtl/dts_lock_ctl.sv
module dts_lock_ctl
  import dts_pkg::*;
#(
  parameter int N_SLOTS = 4,
  localparam int IDXW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sticky,
  input  logic               done,
  input  logic [1:0]         outcome,
  input  logic [IDXW-1:0]    done_slot,
  input  logic [N_SLOTS-1:0] slot_valid,
  output logic               held,
  output logic [IDXW-1:0]    held_slot
);
  logic            lock_q;
  logic [IDXW-1:0] slot_q;
  logic            lock_d;
  logic            slot_en;
  logic            is_retry;

  assign is_retry = (outcome_e'(outcome) == OUT_RETRY);

  always_comb begin
    lock_d  = lock_q;
    slot_en = 1'b0;
    if (done && sticky && is_retry && slot_valid[done_slot]) begin
      lock_d  = 1'b1;
      slot_en = 1'b1;
    end else if (lock_q && (!sticky || !slot_valid[slot_q] || (done && !is_retry))) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      slot_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (slot_en) slot_q <= done_slot;
    end
  end

  assign held      = lock_q && sticky && slot_valid[slot_q];
  assign held_slot = slot_q;
endmodule

// File: rtl/retry_sched.sv
module retry_sched #(
  parameter int N_SLOTS = 4,
  localparam int IDXW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] slot_valid,
  input  logic               sticky_mode,
  input  logic               attempt_done,
  input  logic [1:0]         attempt_outcome,
  output logic               launch,
  output logic [IDXW-1:0]    launch_slot
);
  logic            busy;
  logic [IDXW-1:0] busy_slot;
  logic            done_q;
  logic            rr_found;
  logic [IDXW-1:0] rr_pick;
  logic            held;
  logic [IDXW-1:0] held_slot;

  assign done_q      = attempt_done && busy;
  assign launch      = !busy && (held || rr_found);
  assign launch_slot = held ? held_slot : rr_pick;

  dts_flight #(.N_SLOTS(N_SLOTS)) u_flight (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (launch),
    .start_slot (launch_slot),
    .done       (done_q),
    .busy       (busy),
    .busy_slot  (busy_slot)
  );

  dts_rr_pick #(.N_SLOTS(N_SLOTS)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (slot_valid),
    .adv      (launch),
    .adv_slot (launch_slot),
    .found    (rr_found),
    .pick     (rr_pick)
  );

  dts_lock_ctl #(.N_SLOTS(N_SLOTS)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .sticky     (sticky_mode),
    .done       (done_q),
    .outcome    (attempt_outcome),
    .done_slot  (busy_slot),
    .slot_valid (slot_valid),
    .held       (held),
    .held_slot  (held_slot)
  );
endmodule

// File: rtl/dts_sched_chk.sv
module dts_sched_chk #(
  parameter int N_SLOTS = 4,
  localparam int IDXW = $clog2(N_SLOTS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_SLOTS-1:0] slot_valid,
  input logic               sticky_mode,
  input logic               attempt_done,
  input logic [1:0]         attempt_outcome,
  input logic               launch,
  input logic [IDXW-1:0]    launch_slot
);
  logic            c_busy;
  logic            c_have;
  logic [IDXW-1:0] c_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_busy <= 1'b0;
      c_have <= 1'b0;
      c_last <= '0;
    end else begin
      if (launch) begin
        c_busy <= 1'b1;
        c_have <= 1'b1;
        c_last <= launch_slot;
      end else if (attempt_done) begin
        c_busy <= 1'b0;
      end
    end
  end

  // R1
  a_r1_launch_valid: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> slot_valid[launch_slot]);
  // R1
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid == '0) |-> !launch);
  // R2
  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !c_busy);
  // R5
  a_r5_fair_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !sticky_mode && c_have && ($countones(slot_valid) > 1)) |-> (launch_slot != c_last));
  // R6
  a_r6_sticky_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && attempt_done && sticky_mode && attempt_outcome == 2'b01 && slot_valid[c_last])
      |=> (!sticky_mode || !slot_valid[$past(c_last)] || (launch && launch_slot == $past(c_last))));
  // R9
  a_r9_prompt_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && attempt_done) |=> ((slot_valid == '0) || launch));
endmodule

bind retry_sched dts_sched_chk #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .slot_valid      (slot_valid),
  .sticky_mode     (sticky_mode),
  .attempt_done    (attempt_done),
  .attempt_outcome (attempt_outcome),
  .launch          (launch),
  .launch_slot     (launch_slot)
);

// File: tb/retry_sched_test.sv
module retry_sched_test;
  localparam int N = 4;
  localparam logic [1:0] OC_DONE = 2'b00, OC_RETRY = 2'b01, OC_ERR = 2'b10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] slot_valid;
  logic         sticky_mode;
  logic         attempt_done;
  logic [1:0]   attempt_outcome;
  logic         launch;
  logic [1:0]   launch_slot;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string req_q[$];
  int cyc = 0;

  always #4 clk = ~clk;

  retry_sched #(.N_SLOTS(N)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .slot_valid      (slot_valid),
    .sticky_mode     (sticky_mode),
    .attempt_done    (attempt_done),
    .attempt_outcome (attempt_outcome),
    .launch          (launch),
    .launch_slot     (launch_slot)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every launch pops one expected slot
  always @(negedge clk) begin
    if (rst_n && launch) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected launch", int'(launch_slot), -1);
      end else begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(int'(launch_slot) == e, r, int'(launch_slot), e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "watchdog", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // driver: expect a launch of exp, then answer with oc and update valid bits
  task automatic serve(int exp, logic [1:0] oc, logic [N-1:0] clr, logic [N-1:0] set, string req);
    bit seen;
    seen = 1'b0;
    exp_q.push_back(exp);
    req_q.push_back(req);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (launch) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) check(1'b0, {req, " no launch (R9)"}, 0, 1);
    @(posedge clk); #1;
    attempt_done    = 1'b1;
    attempt_outcome = oc;
    slot_valid      = (slot_valid & ~clr) | set;
    @(negedge clk);
    check(!launch, "R2 launch while outstanding", int'(launch), 0);
    @(posedge clk); #1;
    attempt_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; slot_valid = '0; sticky_mode = 1'b0;
    attempt_done = 1'b0; attempt_outcome = OC_DONE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!launch, "R1 reset quiet", int'(launch), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R2: stray done while idle is ignored
    attempt_done = 1'b1; attempt_outcome = OC_RETRY;
    @(negedge clk);
    check(!launch, "R1 idle no valid", int'(launch), 0);
    @(posedge clk); #1;
    attempt_done = 1'b0;

    // fair mode, all four pending; rotation from slot 0 (R4), retries move on (R5)
    slot_valid = 4'b1111;
    serve(0, OC_RETRY, 4'b0000, 4'b0000, "R4 start slot 0");
    serve(1, OC_RETRY, 4'b0000, 4'b0000, "R5 retry moves on");
    serve(2, OC_RETRY, 4'b0000, 4'b0000, "R5 retry moves on");
    serve(3, OC_RETRY, 4'b0000, 4'b0000, "R5 retry moves on");
    serve(0, OC_DONE,  4'b0001, 4'b0000, "R4 wrap to slot 0");
    serve(1, OC_ERR,   4'b0010, 4'b0000, "R3 error code");
    serve(2, 2'b11,    4'b0100, 4'b0000, "R3 reserved code");
    serve(3, OC_DONE,  4'b1000, 4'b0000, "R4 last slot");
    @(negedge clk);
    check(!launch, "R1 drained quiet", int'(launch), 0);

    // fair mode with holes: slots 1 and 3 only (R4 skip)
    @(posedge clk); #1;
    slot_valid = 4'b1010;
    serve(1, OC_RETRY, 4'b0000, 4'b0000, "R4 skip invalid");
    serve(3, OC_RETRY, 4'b0000, 4'b0000, "R4 skip invalid");
    serve(1, OC_DONE,  4'b0010, 4'b0000, "R5 rotation");
    serve(3, OC_DONE,  4'b1000, 4'b0000, "R4 single left");

    // sticky mode
    @(posedge clk); #1;
    sticky_mode = 1'b1;
    slot_valid  = 4'b1111;
    serve(0, OC_RETRY, 4'b0000, 4'b0000, "R4 pointer after 3");
    serve(0, OC_RETRY, 4'b0000, 4'b0000, "R6 sticky relaunch");
    serve(0, OC_DONE,  4'b0001, 4'b0000, "R6 sticky relaunch");
    serve(1, OC_RETRY, 4'b0000, 4'b0000, "R7 release on completion");
    serve(1, OC_ERR,   4'b0010, 4'b0000, "R6 sticky relaunch");
    serve(2, OC_DONE,  4'b0100, 4'b0000, "R7 release on error");
    serve(3, OC_RETRY, 4'b0000, 4'b0111, "R7 rotation continues");
    serve(3, OC_RETRY, 4'b1000, 4'b0000, "R6 lock holds over others");
    serve(0, OC_DONE,  4'b0001, 4'b0000, "R8 lock dropped with valid");
    serve(1, OC_DONE,  4'b0010, 4'b0000, "R7 rotation");
    serve(2, OC_DONE,  4'b0100, 4'b0000, "R7 rotation");
    @(negedge clk);
    check(!launch, "R1 final quiet", int'(launch), 0);
    check(exp_q.size() == 0, "R2 pending expected launches", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule